// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an 8-bit successive-approximation analog-to-digital converter that serves eight multiplexed analog inputs. A start request captures a 3-bit channel number. The block then runs one conversion of fixed length on a conversion clock that it derives from the system clock. It first opens a sampling window, then tests the eight result bits one at a time on an external trial DAC, and finally publishes the result and raises a completion flag.

The analog multiplexer, the DAC and the comparator sit outside the block. The block drives the multiplexer select and a one-hot route enable that switches the chosen input pin from its port function to the converter. It also drives a sample-enable strobe and the trial DAC code, and it reads back one comparator bit. A small configuration write sets the conversion clock rate. A 2-bit coarse code selects a prescaler ratio of 2, 4 or 16, and a fine bit halves that ratio.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, busy, doneFlag, sampleEn, routeEn, dacCode and resultData are all zero.
- R2: The conversion clock period in system cycles is 2, 4 or 16 for cfgCode 00, 01 or 11 when cfgFine is 0, and 1, 2 or 8 when cfgFine is 1. cfgCode 10 behaves as 11. busy stays high for exactly 160 conversion-clock periods after an accepted start.
- R3: sampleEn is high during the first 12 conversion-clock periods of each conversion and at no other time. dacCode is 0 while sampleEn is high.
- R4: chanSel is captured when a start is accepted, and muxSel holds that value for the whole conversion. While sampleEn is high, routeEn has exactly bit muxSel set. Otherwise routeEn is 0.
- R5: Bit trials run from bit 7 down to bit 0, each lasting 18 conversion-clock periods, with 4 settling periods after the last trial. In the first trial dacCode is 0x80. A bit stays set when compIn is 1 (input at or above the DAC level) and is cleared otherwise, so an ideal comparator gives a result equal to the input code.
- R6: resultData changes only at the end of the 160th conversion-clock period. It holds its previous value throughout a conversion.
- R7: A start request while busy is ignored: it does not shorten or restart the conversion and does not change muxSel.
- R8: doneFlag rises when the result is published. It is cleared by a resultRead pulse or by a newly accepted start, and it stays low during a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Write strobe for the clock configuration |
| cfgCode | input | 2 | Coarse prescaler code |
| cfgFine | input | 1 | Fine select; 1 halves the coarse ratio |
| startReq | input | 1 | Conversion start request |
| chanSel | input | 3 | Channel to convert, captured at start |
| resultRead | input | 1 | Result read strobe; clears doneFlag |
| compIn | input | 1 | Comparator: 1 when input is at or above dacCode |
| muxSel | output | 3 | Analog multiplexer select |
| routeEn | output | 8 | One-hot pin-to-converter route enable during sampling |
| sampleEn | output | 1 | Sample-and-hold enable |
| dacCode | output | 8 | Trial DAC code |
| resultData | output | 8 | Last published conversion result |
| doneFlag | output | 1 | Conversion complete / interrupt flag |
| busy | output | 1 | Conversion in progress |

## Verification
The embedded properties assume that compIn settles within the same system cycle in which dacCode changes, as a combinational comparator would. They also assume that the clock configuration is not rewritten during a conversion, because the divider applies a new ratio at once. The bench models the comparator as a direct compare of a stored per-channel code against dacCode, and it issues configuration writes only while the block is idle. It places resultRead pulses only between conversions, so none of these assumptions is broken.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Converter resolution in bits
  localparam int RES = 8;
  localparam int IDX_W = $clog2(RES);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_TRIAL,
    PH_SETTLE
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             clearAll;  // start accepted this cycle
    logic             trialOn;   // a bit trial is in progress
    logic             decide;    // last cycle of a trial: take comparator
    logic             commit;    // publish result
    logic [IDX_W-1:0] bitIdx;    // bit under trial
  } strobe_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int DIV_C0 = 2,
  parameter int DIV_C1 = 4,
  parameter int DIV_C3 = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic [1:0] cfgCode,
  input  logic       cfgFine,
  input  logic       run,
  output logic       tick
);
  localparam int RW = $clog2(DIV_C3) + 1;

  logic [1:0]    codeReg;
  logic          fineReg;
  logic [RW-1:0] coarse;
  logic [RW-1:0] ratio;
  logic [RW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= 2'b00;
      fineReg <= 1'b0;
    end else if (cfgWrite) begin
      codeReg <= cfgCode;
      fineReg <= cfgFine;
    end
  end

  // Code 10 is reserved and folds onto code 11
  always_comb begin
    unique case (codeReg)
      2'b00:   coarse = RW'(DIV_C0);
      2'b01:   coarse = RW'(DIV_C1);
      default: coarse = RW'(DIV_C3);
    endcase
    ratio = fineReg ? (coarse >> 1) : coarse;
  end

  assign tick = run && (divCnt == ratio - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divCnt <= '0;
    else if (!run)      divCnt <= '0;
    else if (tick)      divCnt <= '0;
    else                divCnt <= divCnt + 1'b1;
  end

  assert_tick_in_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> run);
  assert_cnt_below_ratio_R2: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (divCnt < ratio));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int SAMPLE_LEN = 12,
  parameter int TOTAL_LEN  = 160
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    tick,
  output logic    busy,
  output logic    sampleEn,
  output strobe_t strb
);
  localparam int TRIAL_LEN = (TOTAL_LEN - SAMPLE_LEN) / RES;
  localparam int TAIL_LEN  = TOTAL_LEN - SAMPLE_LEN - RES * TRIAL_LEN;
  localparam int PW        = $clog2(TOTAL_LEN);

  phase_e           phase;
  logic [PW-1:0]    phaseCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             startAcc;
  logic             lastSample;
  logic             lastTrial;
  logic             lastTail;

  assign startAcc   = startReq && (phase == PH_IDLE);
  assign lastSample = (phaseCnt == PW'(SAMPLE_LEN - 1));
  assign lastTrial  = (phaseCnt == PW'(TRIAL_LEN - 1));
  assign lastTail   = (phaseCnt == PW'(TAIL_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startAcc) begin
            phase    <= PH_SAMPLE;
            phaseCnt <= '0;
          end
        end
        PH_SAMPLE: begin
          if (tick) begin
            if (lastSample) begin
              phase    <= PH_TRIAL;
              phaseCnt <= '0;
              bitIdx   <= IDX_W'(RES - 1);
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
        end
        PH_TRIAL: begin
          if (tick) begin
            if (lastTrial) begin
              phaseCnt <= '0;
              if (bitIdx == '0) phase <= (TAIL_LEN == 0) ? PH_IDLE : PH_SETTLE;
              else              bitIdx <= bitIdx - 1'b1;
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
        end
        PH_SETTLE: begin
          if (tick) begin
            if (lastTail) begin
              phase    <= PH_IDLE;
              phaseCnt <= '0;
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign sampleEn = (phase == PH_SAMPLE);

  always_comb begin
    strb.clearAll = startAcc;
    strb.trialOn  = (phase == PH_TRIAL);
    strb.decide   = tick && (phase == PH_TRIAL) && lastTrial;
    strb.commit   = tick && (((phase == PH_SETTLE) && lastTail) ||
                    ((TAIL_LEN == 0) && (phase == PH_TRIAL) && lastTrial && (bitIdx == '0)));
    strb.bitIdx   = bitIdx;
  end

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !tick) |=> ($stable(phase) && $stable(phaseCnt)));
  assert_sample_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> sampleEn);
  assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.trialOn) |-> (strb.bitIdx == IDX_W'(RES - 1)));
endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strb,
  input  logic           sampleEn,
  input  logic [CW-1:0]  chanSel,
  input  logic           compIn,
  input  logic           resultRead,
  output logic [CW-1:0]  muxSel,
  output logic [NCH-1:0] routeEn,
  output logic [RES-1:0] dacCode,
  output logic [RES-1:0] resultData,
  output logic           doneFlag
);
  logic [CW-1:0]  chanReg;
  logic [RES-1:0] sarReg;
  logic [RES-1:0] sarNext;
  logic [RES-1:0] resultReg;
  logic           doneReg;

  always_comb begin
    sarNext = sarReg;
    if (strb.decide && compIn) sarNext[strb.bitIdx] = 1'b1;
    if (strb.clearAll)         sarNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg   <= '0;
      sarReg    <= '0;
      resultReg <= '0;
      doneReg   <= 1'b0;
    end else begin
      sarReg <= sarNext;
      if (strb.clearAll) chanReg <= chanSel;
      if (strb.commit)   resultReg <= sarNext;
      if (strb.commit)                       doneReg <= 1'b1;
      else if (strb.clearAll || resultRead)  doneReg <= 1'b0;
    end
  end

  assign muxSel     = chanReg;
  assign routeEn    = sampleEn ? (NCH'(1) << chanReg) : '0;
  assign dacCode    = sarReg | (strb.trialOn ? (RES'(1) << strb.bitIdx) : '0);
  assign resultData = resultReg;
  assign doneFlag   = doneReg;

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(resultReg));
  assert_done_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> doneFlag);
  assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAll |=> $stable(chanReg));
  assert_route_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(routeEn));
  assert_clear_rule_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && !compIn && !strb.clearAll) |=> (sarReg[$past(strb.bitIdx)] == 1'b0));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int SAMPLE_LEN = 12,
  parameter int TOTAL_LEN  = 160,
  parameter int DIV_C0     = 2,
  parameter int DIV_C1     = 4,
  parameter int DIV_C3     = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWrite,
  input  logic [1:0]     cfgCode,
  input  logic           cfgFine,
  input  logic           startReq,
  input  logic [CW-1:0]  chanSel,
  input  logic           resultRead,
  input  logic           compIn,
  output logic [CW-1:0]  muxSel,
  output logic [NCH-1:0] routeEn,
  output logic           sampleEn,
  output logic [RES-1:0] dacCode,
  output logic [RES-1:0] resultData,
  output logic           doneFlag,
  output logic           busy
);
  logic    tick;
  strobe_t strb;

  sar_clkdiv #(.DIV_C0(DIV_C0), .DIV_C1(DIV_C1), .DIV_C3(DIV_C3)) uDiv (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgCode(cfgCode),
    .cfgFine(cfgFine), .run(busy), .tick(tick)
  );

  sar_ctrl #(.SAMPLE_LEN(SAMPLE_LEN), .TOTAL_LEN(TOTAL_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tick(tick),
    .busy(busy), .sampleEn(sampleEn), .strb(strb)
  );

  sar_dpath #(.NCH(NCH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleEn(sampleEn),
    .chanSel(chanSel), .compIn(compIn), .resultRead(resultRead),
    .muxSel(muxSel), .routeEn(routeEn), .dacCode(dacCode),
    .resultData(resultData), .doneFlag(doneFlag)
  );
endmodule

// File: tb/sim_sar_sequencer.sv
module sim_sar_sequencer;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWrite;
  logic [1:0] cfgCode;
  logic       cfgFine;
  logic       startReq;
  logic [2:0] chanSel;
  logic       resultRead;
  logic       compIn;
  logic [2:0] muxSel;
  logic [7:0] routeEn;
  logic       sampleEn;
  logic [7:0] dacCode;
  logic [7:0] resultData;
  logic       doneFlag;
  logic       busy;

  logic [7:0] anaVal [8];
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  // Ideal comparator
  assign compIn = (anaVal[muxSel] >= dacCode);

  sar_sequencer u0 (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgCode(cfgCode), .cfgFine(cfgFine),
    .startReq(startReq), .chanSel(chanSel), .resultRead(resultRead), .compIn(compIn),
    .muxSel(muxSel), .routeEn(routeEn), .sampleEn(sampleEn), .dacCode(dacCode),
    .resultData(resultData), .doneFlag(doneFlag), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      nFails++;
      $display("FAIL R2 watchdog expired: actual=%0d expected<%0d", cycles, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expDiv(input int code, input int fine);
    int c;
    c = (code == 0) ? 2 : (code == 1) ? 4 : 16;
    return fine ? c / 2 : c;
  endfunction

  task automatic setCfg(input int code, input int fine);
    @(negedge clk);
    cfgWrite = 1'b1; cfgCode = 2'(code); cfgFine = fine[0];
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic readResult(input int val);
    @(negedge clk);
    resultRead = 1'b1;
    @(negedge clk);
    resultRead = 1'b0;
    chk(doneFlag == 1'b0, "R8", "done cleared by read", int'(doneFlag), 0);
    chk(resultData == 8'(val), "R6", "result kept after read", int'(resultData), val);
  endtask

  task automatic doConv(input int ch, input int val, input int dv, input bit poke);
    logic [7:0] prevRes;
    bit doneBefore;
    int busyCyc = 0, sampCyc = 0, muxBad = 0, stableBad = 0;
    int routeBad = 0, dacSampBad = 0, doneBad = 0, dacFirst = -1;
    @(negedge clk);
    anaVal[ch] = 8'(val);
    prevRes = resultData;
    doneBefore = doneFlag;
    startReq = 1'b1; chanSel = 3'(ch);
    @(negedge clk);
    startReq = 1'b0; chanSel = 3'((ch + 3) % 8);
    if (doneBefore) chk(doneFlag == 1'b0, "R8", "done cleared by new start", int'(doneFlag), 0);
    while (busy) begin
      busyCyc++;
      if (muxSel != 3'(ch)) muxBad++;
      if (resultData != prevRes) stableBad++;
      if (sampleEn) begin
        sampCyc++;
        if (routeEn != 8'(1 << ch)) routeBad++;
        if (dacCode != 8'd0) dacSampBad++;
      end else if (routeEn != 8'd0) routeBad++;
      if (busyCyc == 12 * dv + 1) dacFirst = int'(dacCode);
      if (doneFlag) doneBad++;
      if (poke && busyCyc == 40) begin
        startReq = 1'b1; chanSel = 3'((ch + 5) % 8);
      end else startReq = 1'b0;
      if (busyCyc > 4000) break;
      @(negedge clk);
    end
    startReq = 1'b0;
    chk(busyCyc == 160 * dv, "R2", "busy length", busyCyc, 160 * dv);
    chk(sampCyc == 12 * dv, "R3", "sample window", sampCyc, 12 * dv);
    chk(dacSampBad == 0, "R3", "dac nonzero during sampling", dacSampBad, 0);
    chk(muxBad == 0, "R4", "mux select changed", muxBad, 0);
    chk(routeBad == 0, "R4", "route enable wrong", routeBad, 0);
    chk(dacFirst == 128, "R5", "first trial dac", dacFirst, 128);
    chk(resultData == 8'(val), "R5", "conversion result", int'(resultData), val);
    chk(stableBad == 0, "R6", "result moved mid-conversion", stableBad, 0);
    chk(doneFlag == 1'b1 && doneBad == 0, "R8", "done set only at end", int'(doneFlag) + 2 * doneBad, 1);
    if (poke) chk(busyCyc == 160 * dv && muxBad == 0, "R7", "busy start ignored", busyCyc, 160 * dv);
  endtask

  initial begin
    rstN = 1'b0; cfgWrite = 1'b0; cfgCode = 2'b00; cfgFine = 1'b0;
    startReq = 1'b0; chanSel = 3'd0; resultRead = 1'b0;
    for (int i = 0; i < 8; i++) anaVal[i] = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(doneFlag == 1'b0, "R1", "done after reset", int'(doneFlag), 0);
    chk(sampleEn == 1'b0 && routeEn == 8'd0, "R1", "sample/route after reset", int'(routeEn), 0);
    chk(dacCode == 8'd0, "R1", "dac after reset", int'(dacCode), 0);
    chk(resultData == 8'd0, "R1", "result after reset", int'(resultData), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 every prescaler code and fine setting, code 10 included
    for (int code = 0; code < 4; code++) begin
      for (int fine = 0; fine < 2; fine++) begin
        setCfg(code, fine);
        doConv((code * 2 + fine) % 8, (37 * (code * 2 + fine) + 11) & 255,
               expDiv(code, fine), code == 2);
        readResult((37 * (code * 2 + fine) + 11) & 255);
      end
    end

    // R5 full code sweep at the fastest rate; alternate done clearing paths
    setCfg(0, 1);
    for (int v = 0; v < 256; v++) begin
      doConv(v % 8, v, 1, (v % 16) == 5);
      if (v % 2 == 1) readResult(v);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule